// File: doc/BRIEF.md
# Burst Data Mask Pipeline

This block sits in the data path of a synchronous DRAM device model. It applies a per-cycle, per-byte-lane mask to burst transfers. During a write burst the mask blocks the current beat at once: a masked lane gets no write enable toward the array on the edge where the mask is high. During a read burst the mask acts two clock edges later. A mask bit sampled on one rising edge turns off the output enable of its lane for the data cycle that ends on the second rising edge after it. The bus then floats for that lane.

The data width is a parameter of 8 or 16 bits, with one mask bit per byte lane. Mask bit 0 controls bits 7:0 and mask bit 1 controls bits 15:8. A clock-enable input marks suspended cycles. While it is low, the read-mask pipeline keeps its contents and nothing is written. The burst counter, command decoder and array sit outside the block. They appear only as the read-valid, write-valid and data pins.

The stream pins have no back-pressure of their own. The only stall is a low clock enable, and the agent that drives the burst must hold its beat across that stall. Both data paths accept one beat per enabled cycle.

Top module: `burst_lane_mask`

## Requirements
- R1: Write lane `i` is enabled (`arr_we[i]`=1) in a cycle exactly when `wr_valid`=1, `clk_en`=1 and `lane_mask[i]`=0 in that same cycle, so the write mask has zero latency.
- R2: A `lane_mask[i]` value sampled on an enabled rising edge k decides `dq_oe[i]` during the cycle that follows enabled edge k+1. In that cycle `dq_oe[i]` = `rd_valid` AND NOT that mask bit, so the read mask has a latency of two enabled edges.
- R3: Lanes are independent. Mask bit 0 gates data bits 7:0 and mask bit 1 gates bits 15:8, on both the write enables and the output enables.
- R4: Masking is decided separately for every cycle, so any single beat, or any set of beats, of a read or write burst can be gated while its neighbours pass.
- R5: On a rising edge with `clk_en`=0 the read-mask pipeline holds its contents, the mask on that edge is not sampled, and no lane is write-enabled in that cycle.
- R6: `dq_oe[i]` is never 1 while `rd_valid`=0. `dq_out` carries `rd_data` on enabled lanes and zero on disabled lanes.
- R7: After reset the read-mask pipeline is empty. For the first two enabled edges after reset, `dq_oe` equals `rd_valid` on every lane.
- R8: `arr_wdata` equals `wr_data` in every cycle. Only the per-lane enables decide what is stored.
- R9: A write beat and a read beat can occur in the same cycle. Each is masked by its own rule and neither disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; 0 suspends the cycle |
| lane_mask | input | DATA_W/8 | Per-lane mask, one bit per byte lane |
| wr_valid | input | 1 | A write beat is present this cycle |
| wr_data | input | DATA_W | Write data from the bus |
| rd_valid | input | 1 | Array read data is valid this cycle |
| rd_data | input | DATA_W | Read data from the array |
| arr_we | output | DATA_W/8 | Per-lane write enable toward the array |
| arr_wdata | output | DATA_W | Write data toward the array |
| dq_oe | output | DATA_W/8 | Per-lane output enable for the tristate bus |
| dq_out | output | DATA_W | Read data, zeroed on disabled lanes |

## Verification
A write beat and a read beat can land in the same cycle. The current mask then gates the write enables while a mask from two enabled edges earlier gates the output enables. The bench provokes this with random stretches where `wr_valid`, `rd_valid`, `lane_mask` and `clk_en` all toggle together. A behavioural reference model keeps a queue of sampled masks and is compared against every output on every cycle, so a mix-up between the current mask and the delayed mask, or a pipeline that advances across a suspended edge, shows up as a mismatch on the lane concerned.

// File: rtl/lane_mask_pkg.sv
package lane_mask_pkg;
  localparam int unsigned LANE_BITS = 8;
  localparam int unsigned RD_MASK_LAT = 2;

  function automatic int unsigned lanes_of(input int unsigned width);
    return width / LANE_BITS;
  endfunction
endpackage

// File: rtl/lane_rd_delay.sv
module lane_rd_delay #(
  parameter int unsigned DEPTH = lane_mask_pkg::RD_MASK_LAT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic mask_in,
  output logic mask_dly
);
  logic [DEPTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (clk_en) begin
      stage_q[0] <= mask_in;
      for (int s = 1; s < int'(DEPTH); s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign mask_dly = stage_q[DEPTH-1];

  // R5: a suspended edge leaves the pipeline unchanged
  a_r5_hold_on_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(stage_q));

  // R2: an enabled edge moves the first stage into the output stage
  a_r2_stage_advance: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> (mask_dly == $past(stage_q[DEPTH-2])));
endmodule

// File: rtl/lane_wr_gate.sv
module lane_wr_gate #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             wr_valid,
  input  logic [LANES-1:0] lane_mask,
  output logic [LANES-1:0] lane_we
);
  logic beat_live;

  assign beat_live = wr_valid & clk_en;

  always_comb begin
    for (int i = 0; i < int'(LANES); i++) begin
      lane_we[i] = beat_live & ~lane_mask[i];
    end
  end

  // R1: a masked lane never receives a write enable
  a_r1_masked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we & lane_mask) == '0);

  // R5: nothing is written while the clock is suspended
  a_r5_no_write_suspended: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> (lane_we == '0));
endmodule

// File: rtl/burst_lane_mask.sv
module burst_lane_mask
  import lane_mask_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned LANES = DATA_W / LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic [LANES-1:0]  lane_mask,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic [LANES-1:0]  arr_we,
  output logic [DATA_W-1:0] arr_wdata,
  output logic [LANES-1:0]  dq_oe,
  output logic [DATA_W-1:0] dq_out
);
  logic [LANES-1:0] mask_dly;

  lane_wr_gate #(.LANES(LANES)) u_wr_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .wr_valid  (wr_valid),
    .lane_mask (lane_mask),
    .lane_we   (arr_we)
  );

  assign arr_wdata = wr_data;

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    lane_rd_delay #(.DEPTH(RD_MASK_LAT)) u_rd_delay (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_en   (clk_en),
      .mask_in  (lane_mask[g]),
      .mask_dly (mask_dly[g])
    );

    assign dq_oe[g] = rd_valid & ~mask_dly[g];
    assign dq_out[g*LANE_BITS +: LANE_BITS] =
      dq_oe[g] ? rd_data[g*LANE_BITS +: LANE_BITS] : '0;
  end

  // R6: the bus is never driven without valid read data
  a_r6_oe_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (dq_oe == '0));

  // R8: write data reaches the array untouched
  a_r8_wdata_pass: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wdata == wr_data);
endmodule

// File: tb/sim_burst_lane_mask.sv
module sim_burst_lane_mask;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANES = DATA_W / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b1;
  logic [LANES-1:0] lane_mask = '0;
  logic wr_valid = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic rd_valid = 1'b0;
  logic [DATA_W-1:0] rd_data = '0;
  logic [LANES-1:0] arr_we;
  logic [DATA_W-1:0] arr_wdata;
  logic [LANES-1:0] dq_oe;
  logic [DATA_W-1:0] dq_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [LANES-1:0] hist[$];

  always #4 clk = ~clk;

  burst_lane_mask #(.DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .lane_mask(lane_mask),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .arr_we(arr_we), .arr_wdata(arr_wdata),
    .dq_oe(dq_oe), .dq_out(dq_out)
  );

  // Reference model: masks sampled on enabled edges, newest first
  always @(posedge clk) begin
    if (!rst_n) hist.delete();
    else if (clk_en) begin
      hist.push_front(lane_mask);
      if (hist.size() > 4) void'(hist.pop_back());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic compare(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cycles, act, exp);
    end
  endtask

  // Checks every output against the model in the middle of the cycle
  task automatic check_cycle(input string phase);
    logic [LANES-1:0] dmask, exp_we, exp_oe;
    logic [DATA_W-1:0] exp_dq;
    dmask = (hist.size() >= 2) ? hist[1] : '0;
    exp_we = (wr_valid && clk_en) ? ~lane_mask : '0;
    exp_oe = rd_valid ? ~dmask : '0;
    for (int i = 0; i < int'(LANES); i++)
      exp_dq[i*8 +: 8] = exp_oe[i] ? rd_data[i*8 +: 8] : 8'h00;
    compare({phase, " R1 write enables"}, DATA_W'(arr_we), DATA_W'(exp_we));
    compare({phase, " R2 output enables"}, DATA_W'(dq_oe), DATA_W'(exp_oe));
    compare({phase, " R6 read data"}, dq_out, exp_dq);
    compare({phase, " R8 write data"}, arr_wdata, wr_data);
  endtask

  task automatic beat(input string phase, input logic ce, input logic [LANES-1:0] m,
                      input logic wv, input logic rv);
    @(negedge clk);
    clk_en = ce; lane_mask = m; wr_valid = wv; rd_valid = rv;
    wr_data = DATA_W'($urandom); rd_data = DATA_W'($urandom);
    #1;
    check_cycle(phase);
  endtask

  initial begin
    lane_mask = 2'b11; rd_valid = 1'b1;
    repeat (3) @(posedge clk);
    // R7: reset state, pipeline empty so all lanes enabled
    #1;
    compare("R7 oe in reset", DATA_W'(dq_oe), DATA_W'(2'b11));
    compare("R7 we in reset", DATA_W'(arr_we), '0);
    @(negedge clk); rst_n = 1'b1;
    beat("R7", 1'b1, 2'b11, 1'b0, 1'b1);
    beat("R7", 1'b1, 2'b00, 1'b0, 1'b1);
    beat("R7", 1'b1, 2'b00, 1'b0, 1'b1);
    // R3: lanes independent, low lane then high lane
    beat("R3", 1'b1, 2'b01, 1'b1, 1'b1);
    beat("R3", 1'b1, 2'b10, 1'b1, 1'b1);
    beat("R3", 1'b1, 2'b00, 1'b1, 1'b1);
    beat("R3", 1'b1, 2'b00, 1'b1, 1'b1);
    // R4: single beat gated inside a burst
    for (int k = 0; k < 8; k++)
      beat("R4", 1'b1, (k == 3) ? 2'b11 : 2'b00, 1'b1, 1'b1);
    // R5: suspend with masks changing, then resume
    beat("R5", 1'b1, 2'b10, 1'b0, 1'b1);
    beat("R5", 1'b1, 2'b01, 1'b0, 1'b1);
    for (int k = 0; k < 4; k++) beat("R5", 1'b0, 2'b11, 1'b1, 1'b1);
    beat("R5", 1'b1, 2'b00, 1'b1, 1'b1);
    beat("R5", 1'b1, 2'b00, 1'b1, 1'b1);
    beat("R5", 1'b1, 2'b00, 1'b1, 1'b1);
    // R6: no read data valid
    beat("R6", 1'b1, 2'b00, 1'b0, 1'b0);
    beat("R6", 1'b1, 2'b00, 1'b0, 1'b0);
    // R9: reads and writes together under random masks and suspends
    for (int k = 0; k < 2000; k++)
      beat("R9", ($urandom % 5) != 0, LANES'($urandom), 1'($urandom), 1'($urandom));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule